// File: doc/BRIEF.md
# Sampling Converter Serial Output Port

This block is the digital read-out side of a 16-bit sampling converter. A conversion-start input begins a conversion, and a serial clock then shifts the two's complement result out one bit at a time on a serial data line. An output-enable tells the pad when to drive that line and when to leave it at high impedance. The converter core is modelled inside the block as a timer. It captures the parallel sample value at the start edge and presents it as the result a fixed number of clock cycles later. The result can be read as soon as the conversion ends. There is no pipeline delay.

The interface mode is latched from the serial input at each accepted start edge. In select mode the serial input, together with the start line, acts as an active-low select. The block can also raise a busy/done indicator on the data line before the data bits. In chain mode, each serial clock falling edge moves the serial input level one place through the block. Several converters can then share one data line: the one nearest the host delivers its own 16 bits first, followed by the bits of the converters further up the chain.

All inputs are synchronous to `clk_i`. The serial clock edges are found by comparing each sample with the value registered on the previous clock.

Top module: `cvp_serial_port`

## Requirements
- R1: After reset the output enable is low and no read is pending until a conversion has completed.
- R2: On a rising edge of the start line while no conversion runs, a serial-input level of 0 selects chain mode and 1 selects select mode. A rising edge during a conversion is ignored: it changes neither the mode nor the captured sample.
- R3: In select mode the output is enabled while the start line or the serial input is low, and is at high impedance while both are high. It also goes to high impedance after the 16th data bit has been clocked out.
- R4: The result is shifted out MSB (bit 15) first. Bit 15 is on the line as soon as the port is selected after completion, and each accepted serial clock falling edge moves on by one bit.
- R5: In select mode, if the port is selected in the cycle that the conversion completes, the line reads 0 during the conversion and 1 after it ends. The first falling edge then presents bit 15.
- R6: In chain mode, the serial input level seen at a falling edge appears on the data line 16 falling edges later. With two chained ports, 32 edges deliver the near port's result and then the far port's result.
- R7: In chain mode the output is disabled while converting and enabled otherwise.
- R8: Serial clock falling edges are ignored while converting, and in select mode also while the port is not selected.
- R9: If a serial clock falling edge arrives in the same clock cycle as conversion completion, the new result is loaded and that edge shifts nothing.
- R10: The result equals the sample value present at the accepted start edge, and is loaded CONV_CYCLES clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Conversion start / select line |
| sck_i | input | 1 | Serial clock; acts on falling edges |
| sdi_i | input | 1 | Serial input: mode strap, select, or chain data |
| sample_i | input | WIDTH | Sample value the modelled core converts |
| sdo_o | output | 1 | Serial data line value |
| sdo_oe_o | output | 1 | Drive enable for the serial data line |

## Verification
Two events can land in the same clock cycle: the end of a conversion, which loads the shift register, and a serial clock falling edge, which would shift it. The bench provokes this in chain mode by placing the falling edge on the exact cycle the result loads. It then judges the outcome by requiring that bit 15 of the new result is still the first bit on the line and that all 32 chained bits follow in order. A second overlap is a start edge arriving during a conversion; this is judged by changing the sample before that edge and expecting the original value to be read out.

// File: rtl/cvp_pkg.sv
package cvp_pkg;
  typedef enum logic {
    MODE_SEL   = 1'b0,
    MODE_CHAIN = 1'b1
  } port_mode_e;
endpackage

// File: rtl/cvp_conv_timer.sv
module cvp_conv_timer #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      result_o <= '0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      cnt_q    <= LOAD_VAL;
      result_o <= sample_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  assert_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && result_o == $past(sample_i)));
  assert_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(result_o));
endmodule

// File: rtl/cvp_mode_ctl.sv
module cvp_mode_ctl
  import cvp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       busy_i,
  input  logic       cnv_i,
  input  logic       sdi_i,
  input  logic       sck_fall_i,
  output port_mode_e mode_o,
  output logic       shift_o,
  output logic       lead_o,
  output logic       oe_o
);
  localparam int BW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  port_mode_e    mode_q;
  logic          lead_q, drained_q;
  logic [BW-1:0] bitcnt_q;
  logic          sel, edge_ok, lead_adv;

  assign sel      = !cnv_i || !sdi_i;
  assign edge_ok  = sck_fall_i && !busy_i && !done_i;
  assign lead_adv = edge_ok && (mode_q == MODE_SEL) && sel && lead_q && !drained_q;

  always_comb begin
    if (mode_q == MODE_CHAIN) shift_o = edge_ok;
    else                      shift_o = edge_ok && sel && !drained_q && !lead_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_SEL;
      lead_q    <= 1'b0;
      drained_q <= 1'b1;
      bitcnt_q  <= '0;
    end else if (start_i) begin
      mode_q    <= sdi_i ? MODE_SEL : MODE_CHAIN;
      lead_q    <= 1'b0;
      drained_q <= 1'b0;
      bitcnt_q  <= '0;
    end else if (done_i) begin
      lead_q   <= (mode_q == MODE_SEL) && sel;
      bitcnt_q <= '0;
    end else begin
      if (lead_adv) lead_q <= 1'b0;
      if (shift_o && mode_q == MODE_SEL) begin
        if (bitcnt_q == LAST_BIT) drained_q <= 1'b1;
        bitcnt_q <= bitcnt_q + 1'b1;
      end
    end
  end

  assign mode_o = mode_q;
  assign lead_o = lead_q;
  assign oe_o   = (mode_q == MODE_CHAIN) ? !busy_i : (sel && !drained_q);

  assert_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(mode_q));
  assert_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SEL && shift_o && bitcnt_q == LAST_BIT && !start_i) |=> !oe_o);
  assert_lead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lead_q) && !$past(start_i)) |-> $past(sck_fall_i));
  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SEL && cnv_i && sdi_i) |-> !shift_o);
endmodule

// File: rtl/cvp_shifter.sv
module cvp_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[WIDTH-2:0], ser_i};
  end

  assign msb_o = sreg_q[WIDTH-1];

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> msb_o == $past(data_i[WIDTH-1]));
  assert_chain_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> sreg_q[0] == $past(ser_i));
endmodule

// File: rtl/cvp_serial_port.sv
module cvp_serial_port
  import cvp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnv_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  logic             cnv_q, sck_q;
  logic             cnv_rise, sck_fall, start;
  logic             conv_busy, conv_done, shift, lead, msb;
  logic [WIDTH-1:0] result;
  port_mode_e       mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_i;
      sck_q <= sck_i;
    end
  end

  assign cnv_rise = cnv_i && !cnv_q;
  assign sck_fall = !sck_i && sck_q;
  assign start    = cnv_rise && !conv_busy;

  cvp_conv_timer #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cnv_rise),
    .sample_i (sample_i),
    .busy_o   (conv_busy),
    .done_o   (conv_done),
    .result_o (result)
  );

  cvp_mode_ctl #(.WIDTH(WIDTH)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .done_i     (conv_done),
    .busy_i     (conv_busy),
    .cnv_i      (cnv_i),
    .sdi_i      (sdi_i),
    .sck_fall_i (sck_fall),
    .mode_o     (mode),
    .shift_o    (shift),
    .lead_o     (lead),
    .oe_o       (sdo_oe_o)
  );

  cvp_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (conv_done),
    .data_i  (result),
    .shift_i (shift),
    .ser_i   (sdi_i),
    .msb_o   (msb)
  );

  // busy phase reads low, done marker reads high, then data
  always_comb begin
    if (conv_busy) sdo_o = 1'b0;
    else if (lead) sdo_o = 1'b1;
    else           sdo_o = msb;
  end

  assert_busy_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_busy) |-> !sdo_o);
  assert_chain_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_CHAIN && !conv_busy) |-> sdo_oe_o);
  assert_busy_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_busy && sck_fall) |-> !shift);
endmodule

// File: tb/cvp_serial_port_bench.sv
module cvp_serial_port_bench;
  localparam int W    = 16;
  localparam int CONV = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv = 1'b0, sck = 1'b0, sdi_drv = 1'b1, chain_en = 1'b0;
  logic [W-1:0] dn_sample = '0, up_sample = '0;
  logic         dn_sdo, dn_oe, up_sdo, up_oe, dn_sdi;
  int           n_chk = 0, n_bad = 0;
  bit           done_flag = 0;
  logic         exp_q[$];

  always #2 clk = ~clk;

  assign dn_sdi = chain_en ? up_sdo : sdi_drv;

  cvp_serial_port #(.WIDTH(W), .CONV_CYCLES(CONV)) u_cvp_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(dn_sdi),
    .sample_i(dn_sample), .sdo_o(dn_sdo), .sdo_oe_o(dn_oe));

  cvp_serial_port #(.WIDTH(W), .CONV_CYCLES(CONV)) u_up (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(1'b0),
    .sample_i(up_sample), .sdo_o(up_sdo), .sdo_oe_o(up_oe));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sck_pulse();
    sck = 1'b1; tick();
    sck = 1'b0; tick();
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_bits(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic read_bits(string req, int n);
    for (int i = 0; i < n; i++) begin
      logic e;
      e = exp_q.pop_front();
      check(req, {31'b0, dn_sdo}, {31'b0, e});
      sck_pulse();
    end
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 oe after reset", {31'b0, dn_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) tick();
    cnv = 1'b0; sdi_drv = 1'b0; tick();
    check("R1 no pending read", {31'b0, dn_oe}, 32'd0);

    // select mode, no busy marker; restart edge mid-conversion ignored
    sdi_drv = 1'b1; dn_sample = 16'hA5C3; cnv = 1'b1; tick();
    check("R3 hiz when both high", {31'b0, dn_oe}, 32'd0);
    dn_sample = 16'h1111;
    cnv = 1'b0; tick();
    cnv = 1'b1; tick();
    repeat (CONV) tick();
    repeat (3) sck_pulse();  // deselected edges, R8
    check("R3 still hiz", {31'b0, dn_oe}, 32'd0);
    cnv = 1'b0; tick();
    check("R3 enabled by cnv low", {31'b0, dn_oe}, 32'd1);
    load_bits(16'hA5C3);
    read_bits("R4 R8 R10 R2 data order", W);
    check("R3 hiz after last bit", {31'b0, dn_oe}, 32'd0);
    sck_pulse();
    check("R3 stays hiz", {31'b0, dn_oe}, 32'd0);

    // select mode with busy marker, deselect mid-read
    sdi_drv = 1'b1; dn_sample = 16'h3C96; cnv = 1'b1; tick();
    sdi_drv = 1'b0; tick();
    check("R5 busy enable", {31'b0, dn_oe}, 32'd1);
    check("R5 busy low", {31'b0, dn_sdo}, 32'd0);
    sck_pulse();  // during conversion, R8
    repeat (CONV) tick();
    check("R5 done high", {31'b0, dn_sdo}, 32'd1);
    sck_pulse();
    load_bits(16'h3C96);
    read_bits("R5 R4 busy read", 8);
    sdi_drv = 1'b1; tick();
    check("R3 deselect mid-read", {31'b0, dn_oe}, 32'd0);
    sck_pulse();  // ignored while deselected, R8
    sdi_drv = 1'b0; tick();
    check("R3 reselect", {31'b0, dn_oe}, 32'd1);
    read_bits("R8 R4 resume", 8);
    check("R3 hiz after busy read", {31'b0, dn_oe}, 32'd0);

    // chain of two, falling edge coinciding with completion
    cnv = 1'b0; sdi_drv = 1'b1; tick();
    chain_en = 1'b1; tick();
    dn_sample = 16'h8000; up_sample = 16'h7FFF; cnv = 1'b1; tick();
    check("R7 oe low converting", {31'b0, dn_oe}, 32'd0);
    repeat (CONV - 2) tick();
    sck = 1'b1; tick();
    sck = 1'b0; tick();
    check("R9 load wins over edge", {31'b0, dn_sdo}, 32'd1);
    check("R9 far port msb", {31'b0, up_sdo}, 32'd0);
    check("R7 oe idle chain", {31'b0, dn_oe}, 32'd1);
    load_bits(16'h8000);
    load_bits(16'h7FFF);
    read_bits("R6 R2 chained 32 bits", 2 * W);
    check("R6 zero after chain", {31'b0, dn_sdo}, 32'd0);
    check("R7 oe held", {31'b0, dn_oe}, 32'd1);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule